// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block sits between a processor's memory management unit and its memory path. It turns logical page numbers into physical page numbers. The requester presents a logical address together with a privilege flag (supervisor or user) and a write flag. It holds the request until the block signals completion. A hit completes in the same cycle and returns the physical address, a two-bit cache-mode attribute and two user attribute bits. A miss raises a request to an external table walker. The walker answers with a one-cycle fill carrying the page descriptor, and the block stores it and then completes the lookup.

The storage has 16 sets of 4 ways. A mode input selects 4 KB or 8 KB pages. Each entry keeps:
- a privilege bit;
- a global bit;
- a dirty (modified) bit;
- a write-protect bit;
- the user attributes;
- the cache mode;
- a 16-bit logical tag;
- a 20-bit physical page number.

A write that hits a clean page is not completed at once. The block holds the write and refetches the descriptor into the same way, and the write completes only after that. A write to a write-protected page completes with a fault. A single-cycle flush command invalidates every entry, every non-global entry, or the one entry that matches an address and a privilege level.

Top module: `xlat_cache`

## Requirements
- R1: After reset, no entry is valid: the first lookup does not complete in its first cycle, and walk_req is low while reset is applied.
- R2: On a miss, walk_req rises in the next cycle and stays high until fill_valid, with walk_addr, walk_priv and walk_write equal to the held request. A fill_valid pulse while no walk is pending changes no entry.
- R3: A hit sets xl_done in the same cycle. In 4 KB mode, xl_paddr is {page number, req_addr[11:0]}. xl_cmode returns the stored mode, where 00 is cachable write-through, 01 cachable copyback, 10 noncachable precise and 11 noncachable imprecise.
- R4: An entry hits only when its stored privilege bit equals req_priv (1 = supervisor, 0 = user).
- R5: In 8 KB mode (page8k=1), the set index is req_addr[16:13] and the tag compare ignores tag bit 0. xl_paddr is {page number[19:1], req_addr[12:0]}.
- R6: A write that hits a write-protected entry completes with xl_fault=1 and xl_paddr=0. A read of the same entry translates normally.
- R7: A write that hits a clean entry (dirty=0) does not complete. It starts a walk with walk_write=1, the fill overwrites that same way, and the write then completes. The other ways of the set are untouched.
- R8: A new fill goes to the lowest invalid way of its set. When the set is full, it goes to the way named by a per-set round-robin pointer. The pointer starts at way 0 and advances by one after each such eviction.
- R9: flush_cmd=01 invalidates every entry.
- R10: flush_cmd=10 invalidates every entry whose global bit is clear, and leaves global entries valid.
- R11: flush_cmd=11 invalidates only the entry that matches flush_addr and flush_priv, whether or not it is global.
- R12: When a flush and a fill land in the same cycle, the flush acts first and the newly filled entry stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page8k | input | 1 | 1 = 8 KB pages, 0 = 4 KB pages |
| req_valid | input | 1 | Lookup request, held until xl_done |
| req_addr | input | 32 | Logical address |
| req_priv | input | 1 | 1 = supervisor, 0 = user |
| req_write | input | 1 | 1 = write access |
| xl_done | output | 1 | Lookup completes this cycle |
| xl_fault | output | 1 | Write to a write-protected page |
| xl_paddr | output | 32 | Physical address (0 unless a clean completion) |
| xl_cmode | output | 2 | Cache-mode attribute |
| xl_uattr | output | 2 | User attribute bits |
| walk_req | output | 1 | Table walk wanted |
| walk_addr | output | 32 | Address to walk |
| walk_priv | output | 1 | Privilege of the walk |
| walk_write | output | 1 | Walk was caused by a write |
| fill_valid | input | 1 | Descriptor valid from the walker |
| fill_ppn | input | 20 | Physical page number |
| fill_cmode | input | 2 | Cache mode |
| fill_global | input | 1 | Global bit |
| fill_dirty | input | 1 | Modified bit |
| fill_wprot | input | 1 | Write-protect bit |
| fill_uattr | input | 2 | User attribute bits |
| flush_cmd | input | 2 | 00 none, 01 all, 10 non-global, 11 single entry |
| flush_addr | input | 32 | Address for a single-entry flush |
| flush_priv | input | 1 | Privilege for a single-entry flush |

## Verification
A flush command and a walker fill can reach the storage on the same clock edge. Then it matters whether the newly written entry survives a flush-all. The bench starts a miss, and during the walk cycle it drives fill_valid and flush_cmd=01 together. It then expects the held request to complete from the new entry, and an entry loaded earlier to miss. A second overlap is also tested: a write that hits a clean entry while its set is full. Here the refetch must land in the hit way rather than in the round-robin victim, and the bench judges this by all four ways still hitting afterwards.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int XL_VA_W    = 32;
    localparam int XL_SETS    = 16;
    localparam int XL_WAYS    = 4;
    localparam int XL_PG_LSB  = 12;
    localparam int XL_IDX_W   = $clog2(XL_SETS);
    localparam int XL_WAY_W   = $clog2(XL_WAYS);
    localparam int XL_TAG_LSB = XL_PG_LSB + XL_IDX_W;
    localparam int XL_TAG_W   = XL_VA_W - XL_TAG_LSB;
    localparam int XL_PPN_W   = XL_VA_W - XL_PG_LSB;

    typedef logic [XL_VA_W-1:0]  vaddr_t;
    typedef logic [XL_TAG_W-1:0] tag_t;
    typedef logic [XL_PPN_W-1:0] ppn_t;
    typedef logic [XL_IDX_W-1:0] idx_t;
    typedef logic [XL_WAY_W-1:0] way_t;

    typedef enum logic [1:0] {
        CM_WTHRU  = 2'b00,
        CM_CBACK  = 2'b01,
        CM_NC_PRE = 2'b10,
        CM_NC_IMP = 2'b11
    } cmode_e;

    typedef enum logic [1:0] {
        FL_NONE   = 2'b00,
        FL_ALL    = 2'b01,
        FL_NONGLB = 2'b10,
        FL_ONE    = 2'b11
    } flush_e;

    typedef struct packed {
        ppn_t       ppn;
        cmode_e     cmode;
        logic       glob;
        logic       dirty;
        logic       wprot;
        logic [1:0] uattr;
    } desc_t;

    typedef struct packed {
        logic       valid;
        logic       priv;
        logic       glob;
        logic       dirty;
        logic       wprot;
        logic [1:0] uattr;
        cmode_e     cmode;
        tag_t       tag;
        ppn_t       ppn;
    } entry_t;

    // Set index: large pages shift the index window up by one bit.
    function automatic idx_t set_of(vaddr_t a, logic big);
        return big ? a[XL_PG_LSB+1 +: XL_IDX_W] : a[XL_PG_LSB +: XL_IDX_W];
    endfunction

    function automatic tag_t tag_of(vaddr_t a);
        return a[XL_VA_W-1:XL_TAG_LSB];
    endfunction

    // Large pages drop the lowest tag bit from the compare.
    function automatic logic tag_eq(tag_t x, tag_t y, logic big);
        return big ? (x[XL_TAG_W-1:1] == y[XL_TAG_W-1:1]) : (x == y);
    endfunction

    function automatic vaddr_t phys_of(ppn_t p, vaddr_t a, logic big);
        vaddr_t r;
        r = {p, a[XL_PG_LSB-1:0]};
        if (big) r[XL_PG_LSB] = a[XL_PG_LSB];
        return r;
    endfunction

endpackage

// File: rtl/xlat_array.sv
module xlat_array
    import xlat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                page8k,
    input  vaddr_t              lk_addr,
    input  logic                lk_priv,
    output logic                lk_hit,
    output way_t                lk_way,
    output entry_t              lk_ent,
    output logic [XL_WAYS-1:0]  lk_vld,
    input  logic                wr_en,
    input  way_t                wr_way,
    input  desc_t               wr_desc,
    input  flush_e              fl_cmd,
    input  vaddr_t              fl_addr,
    input  logic                fl_priv
);

    entry_t ents [XL_SETS][XL_WAYS];

    idx_t   lk_set;
    idx_t   fl_set;
    tag_t   lk_tag;
    tag_t   fl_tag;
    logic [XL_WAYS-1:0]               way_hit;
    logic [XL_SETS-1:0][XL_WAYS-1:0]  kill;
    entry_t new_ent;

    assign lk_set = set_of(lk_addr, page8k);
    assign lk_tag = tag_of(lk_addr);
    assign fl_set = set_of(fl_addr, page8k);
    assign fl_tag = tag_of(fl_addr);

    for (genvar w = 0; w < XL_WAYS; w++) begin : g_way
        assign lk_vld[w]  = ents[lk_set][w].valid;
        assign way_hit[w] = ents[lk_set][w].valid &&
                            (ents[lk_set][w].priv == lk_priv) &&
                            tag_eq(ents[lk_set][w].tag, lk_tag, page8k);
    end

    always_comb begin
        lk_way = '0;
        for (int w = XL_WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) lk_way = way_t'(w);
        end
        lk_hit = |way_hit;
        lk_ent = ents[lk_set][lk_way];
    end

    always_comb begin
        for (int s = 0; s < XL_SETS; s++) begin
            for (int w = 0; w < XL_WAYS; w++) begin
                unique case (fl_cmd)
                    FL_ALL:    kill[s][w] = 1'b1;
                    FL_NONGLB: kill[s][w] = !ents[s][w].glob;
                    FL_ONE:    kill[s][w] = (idx_t'(s) == fl_set) &&
                                            (ents[s][w].priv == fl_priv) &&
                                            tag_eq(ents[s][w].tag, fl_tag, page8k);
                    default:   kill[s][w] = 1'b0;
                endcase
            end
        end
    end

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.priv  = lk_priv;
        new_ent.glob  = wr_desc.glob;
        new_ent.dirty = wr_desc.dirty;
        new_ent.wprot = wr_desc.wprot;
        new_ent.uattr = wr_desc.uattr;
        new_ent.cmode = wr_desc.cmode;
        new_ent.tag   = lk_tag;
        new_ent.ppn   = wr_desc.ppn;
    end

    // Flush first, then the fill, so a same-edge fill survives.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < XL_SETS; s++) begin
                for (int w = 0; w < XL_WAYS; w++) begin
                    ents[s][w].valid <= 1'b0;
                end
            end
        end else begin
            for (int s = 0; s < XL_SETS; s++) begin
                for (int w = 0; w < XL_WAYS; w++) begin
                    if (kill[s][w]) ents[s][w].valid <= 1'b0;
                end
            end
            if (wr_en) ents[lk_set][wr_way] <= new_ent;
        end
    end

    // R8
    single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_hit));

    // R12
    fill_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> lk_hit);

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  idx_t               set,
    input  logic [XL_WAYS-1:0] vld,
    input  logic               take,
    output way_t               victim
);

    way_t rr [XL_SETS];
    logic any_free;
    way_t free_way;

    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int w = XL_WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) begin
                any_free = 1'b1;
                free_way = way_t'(w);
            end
        end
    end

    assign victim = any_free ? free_way : rr[set];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < XL_SETS; s++) rr[s] <= '0;
        end else if (take && !any_free) begin
            rr[set] <= rr[set] + 1'b1;
        end
    end

    // R8
    free_first_chk: assert property (@(posedge clk) disable iff (rst)
        (take && (vld != '1)) |-> !vld[victim]);

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
    import xlat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_write,
    input  logic lk_hit,
    input  way_t lk_way,
    input  logic hit_dirty,
    input  logic hit_wprot,
    input  logic fill_valid,
    input  way_t victim,
    output logic done,
    output logic fault,
    output logic walking,
    output logic wr_en,
    output way_t wr_way,
    output logic take_victim
);

    typedef enum logic {ST_IDLE, ST_WALK} st_e;

    st_e  st;
    logic refetch;
    way_t rf_way;
    logic need_dirty;
    logic start;

    assign need_dirty  = lk_hit && req_write && !hit_wprot && !hit_dirty;
    assign done        = (st == ST_IDLE) && req_valid && lk_hit && !need_dirty;
    assign fault       = done && req_write && hit_wprot;
    assign start       = (st == ST_IDLE) && req_valid && (!lk_hit || need_dirty);
    assign walking     = (st == ST_WALK);
    assign wr_en       = walking && fill_valid;
    assign wr_way      = refetch ? rf_way : victim;
    assign take_victim = wr_en && !refetch;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            refetch <= 1'b0;
            rf_way  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    st      <= ST_WALK;
                    refetch <= need_dirty;
                    rf_way  <= lk_way;
                end
                ST_WALK: if (fill_valid) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R2
    walk_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (walking && !fill_valid) |=> walking);

    // R7
    dirty_before_write_chk: assert property (@(posedge clk) disable iff (rst)
        (done && req_write && !fault) |-> hit_dirty);

    // R7
    refetch_walk_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && lk_hit && req_write && !hit_wprot && !hit_dirty && !walking) |=> walking);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 page8k,
    input  logic                 req_valid,
    input  logic [XL_VA_W-1:0]   req_addr,
    input  logic                 req_priv,
    input  logic                 req_write,
    output logic                 xl_done,
    output logic                 xl_fault,
    output logic [XL_VA_W-1:0]   xl_paddr,
    output logic [1:0]           xl_cmode,
    output logic [1:0]           xl_uattr,
    output logic                 walk_req,
    output logic [XL_VA_W-1:0]   walk_addr,
    output logic                 walk_priv,
    output logic                 walk_write,
    input  logic                 fill_valid,
    input  logic [XL_PPN_W-1:0]  fill_ppn,
    input  logic [1:0]           fill_cmode,
    input  logic                 fill_global,
    input  logic                 fill_dirty,
    input  logic                 fill_wprot,
    input  logic [1:0]           fill_uattr,
    input  logic [1:0]           flush_cmd,
    input  logic [XL_VA_W-1:0]   flush_addr,
    input  logic                 flush_priv
);

    logic               lk_hit;
    way_t               lk_way;
    entry_t             lk_ent;
    logic [XL_WAYS-1:0] lk_vld;
    logic               wr_en;
    way_t               wr_way;
    way_t               victim;
    logic               take_victim;
    desc_t              fdesc;
    logic               good;

    assign fdesc = '{ppn:   fill_ppn,
                     cmode: cmode_e'(fill_cmode),
                     glob:  fill_global,
                     dirty: fill_dirty,
                     wprot: fill_wprot,
                     uattr: fill_uattr};

    xlat_array i_array (
        .clk     (clk),
        .rst     (rst),
        .page8k  (page8k),
        .lk_addr (req_addr),
        .lk_priv (req_priv),
        .lk_hit  (lk_hit),
        .lk_way  (lk_way),
        .lk_ent  (lk_ent),
        .lk_vld  (lk_vld),
        .wr_en   (wr_en),
        .wr_way  (wr_way),
        .wr_desc (fdesc),
        .fl_cmd  (flush_e'(flush_cmd)),
        .fl_addr (flush_addr),
        .fl_priv (flush_priv)
    );

    xlat_victim i_victim (
        .clk    (clk),
        .rst    (rst),
        .set    (set_of(req_addr, page8k)),
        .vld    (lk_vld),
        .take   (take_victim),
        .victim (victim)
    );

    xlat_ctrl i_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .lk_hit      (lk_hit),
        .lk_way      (lk_way),
        .hit_dirty   (lk_ent.dirty),
        .hit_wprot   (lk_ent.wprot),
        .fill_valid  (fill_valid),
        .victim      (victim),
        .done        (xl_done),
        .fault       (xl_fault),
        .walking     (walk_req),
        .wr_en       (wr_en),
        .wr_way      (wr_way),
        .take_victim (take_victim)
    );

    assign good       = xl_done && !xl_fault;
    assign xl_paddr   = good ? phys_of(lk_ent.ppn, req_addr, page8k) : '0;
    assign xl_cmode   = good ? lk_ent.cmode : 2'b00;
    assign xl_uattr   = good ? lk_ent.uattr : 2'b00;
    assign walk_addr  = walk_req ? req_addr  : '0;
    assign walk_priv  = walk_req ? req_priv  : 1'b0;
    assign walk_write = walk_req ? req_write : 1'b0;

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (xl_done && !xl_fault) |-> (xl_paddr[XL_PG_LSB-1:0] == req_addr[XL_PG_LSB-1:0]));

    // R6
    fault_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        xl_fault |-> (req_write && xl_done));

endmodule

// File: tb/test_xlat_cache.sv
module test_xlat_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        page8k = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_priv = 1'b0;
    logic        req_write = 1'b0;
    logic        xl_done, xl_fault;
    logic [31:0] xl_paddr;
    logic [1:0]  xl_cmode, xl_uattr;
    logic        walk_req, walk_priv, walk_write;
    logic [31:0] walk_addr;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_ppn = '0;
    logic [1:0]  fill_cmode = '0;
    logic        fill_global = 1'b0;
    logic        fill_dirty = 1'b0;
    logic        fill_wprot = 1'b0;
    logic [1:0]  fill_uattr = '0;
    logic [1:0]  flush_cmd = '0;
    logic [31:0] flush_addr = '0;
    logic        flush_priv = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 20 ns period, 50 MHz

    xlat_cache i_xlat_cache (.*);

    typedef struct packed {
        logic [31:0] a;
        logic        p;
        logic [19:0] ppn;
        logic [1:0]  cm;
        logic [31:0] pa;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{32'h0001_2345, 1'b0, 20'hABCDE, 2'b00, 32'hABCD_E345},
        '{32'h8000_7FF0, 1'b1, 20'h12345, 2'b01, 32'h1234_5FF0},
        '{32'h0003_2ABC, 1'b0, 20'h00F0F, 2'b10, 32'h00F0_FABC},
        '{32'hFFFF_F001, 1'b1, 20'hFFFFF, 2'b11, 32'hFFFF_F001}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic probe(input logic [31:0] a, input logic p, input logic w,
                         output logic d, output logic f, output logic [31:0] pa,
                         output logic [1:0] cm);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_priv = p; req_write = w;
        #2;
        d = xl_done; f = xl_fault; pa = xl_paddr; cm = xl_cmode;
        #2;
        req_valid = 1'b0;
    endtask

    task automatic set_fill(input logic [19:0] ppn, input logic [1:0] cm,
                            input logic g, input logic dty, input logic wp);
        fill_ppn = ppn; fill_cmode = cm; fill_global = g;
        fill_dirty = dty; fill_wprot = wp; fill_uattr = 2'b10;
    endtask

    task automatic access(input logic [31:0] a, input logic p, input logic w,
                          input logic [19:0] ppn, input logic [1:0] cm,
                          input logic g, input logic dty, input logic wp,
                          output logic walked, output logic [31:0] wa, output logic ww,
                          output logic d, output logic f, output logic [31:0] pa,
                          output logic [1:0] cmo);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_priv = p; req_write = w;
        #2;
        walked = 1'b0; wa = '0; ww = 1'b0;
        if (!xl_done) begin
            @(negedge clk);
            #2;
            walked = walk_req; wa = walk_addr; ww = walk_write;
            set_fill(ppn, cm, g, dty, wp);
            fill_valid = 1'b1;
            @(negedge clk);
            fill_valid = 1'b0;
            #2;
        end
        d = xl_done; f = xl_fault; pa = xl_paddr; cmo = xl_cmode;
        #2;
        req_valid = 1'b0;
    endtask

    task automatic flush(input logic [1:0] c, input logic [31:0] a, input logic p);
        @(negedge clk);
        flush_cmd = c; flush_addr = a; flush_priv = p;
        @(negedge clk);
        flush_cmd = 2'b00;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #4000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic d, f, wk, ww;
        logic [31:0] pa, wa;
        logic [1:0] cm;

        repeat (3) @(negedge clk);
        chk("R1 walk_req in reset", {31'b0, walk_req}, 32'd0);
        rst = 1'b0;

        // R1: empty after reset
        probe(32'h0001_2345, 1'b0, 1'b0, d, f, pa, cm);
        chk("R1 first lookup misses", {31'b0, d}, 32'd0);

        // R2 / R3: table of loads, each a miss followed by a fill
        for (int i = 0; i < 4; i++) begin
            access(VECS[i].a, VECS[i].p, 1'b0, VECS[i].ppn, VECS[i].cm, 1'b0, 1'b0, 1'b0,
                   wk, wa, ww, d, f, pa, cm);
            chk("R2 miss walks", {31'b0, wk}, 32'd1);
            chk("R2 walk addr", wa, VECS[i].a);
            chk("R3 paddr after fill", pa, VECS[i].pa);
        end
        for (int i = 0; i < 4; i++) begin
            probe(VECS[i].a, VECS[i].p, 1'b0, d, f, pa, cm);
            chk("R3 hit done", {31'b0, d}, 32'd1);
            chk("R3 paddr", pa, VECS[i].pa);
            chk("R3 cmode", {30'b0, cm}, {30'b0, VECS[i].cm});
        end

        // R4: privilege mismatch misses
        probe(VECS[0].a, 1'b1, 1'b0, d, f, pa, cm);
        chk("R4 priv mismatch", {31'b0, d}, 32'd0);
        probe(VECS[1].a, 1'b0, 1'b0, d, f, pa, cm);
        chk("R4 priv mismatch user", {31'b0, d}, 32'd0);

        // R2: walk held over several cycles, then fill
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0009_1234; req_priv = 1'b1; req_write = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #2;
            chk("R2 walk_req held", {31'b0, walk_req}, 32'd1);
            chk("R2 walk_priv", {31'b0, walk_priv}, 32'd1);
        end
        set_fill(20'h0BEEF, 2'b01, 1'b0, 1'b1, 1'b0);
        fill_valid = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
        #2;
        chk("R2 done after fill", {31'b0, xl_done}, 32'd1);
        chk("R2 walk_req drops", {31'b0, walk_req}, 32'd0);
        chk("R2 paddr", xl_paddr, 32'h0BEE_F234);
        #2;
        req_valid = 1'b0;
        // R2: stray fill while idle is ignored
        @(negedge clk);
        req_addr = 32'h000A_5000; req_priv = 1'b0;
        set_fill(20'h00777, 2'b00, 1'b0, 1'b1, 1'b0);
        fill_valid = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
        probe(32'h000A_5000, 1'b0, 1'b0, d, f, pa, cm);
        chk("R2 idle fill ignored", {31'b0, d}, 32'd0);

        // R6: write-protect
        access(32'h0005_0000, 1'b0, 1'b0, 20'h11111, 2'b00, 1'b0, 1'b1, 1'b1,
               wk, wa, ww, d, f, pa, cm);
        chk("R6 read of protected page", pa, 32'h1111_1000);
        chk("R6 read no fault", {31'b0, f}, 32'd0);
        probe(32'h0005_0000, 1'b0, 1'b1, d, f, pa, cm);
        chk("R6 write done", {31'b0, d}, 32'd1);
        chk("R6 write fault", {31'b0, f}, 32'd1);
        chk("R6 paddr blank", pa, 32'd0);

        // R7: clean page write refetches into the same way
        for (int i = 0; i < 4; i++) begin
            access({12'h000, 4'(i), 16'h7000}, 1'b0, 1'b0, 20'h00200 + 20'(i), 2'b00,
                   1'b0, 1'b0, 1'b0, wk, wa, ww, d, f, pa, cm);
        end
        access(32'h0001_7000, 1'b0, 1'b1, 20'h22222, 2'b01, 1'b0, 1'b1, 1'b0,
               wk, wa, ww, d, f, pa, cm);
        chk("R7 refetch walk", {31'b0, wk}, 32'd1);
        chk("R7 walk_write", {31'b0, ww}, 32'd1);
        chk("R7 write completes", pa, 32'h2222_2000);
        for (int i = 0; i < 4; i++) begin
            if (i == 1) continue;
            probe({12'h000, 4'(i), 16'h7000}, 1'b0, 1'b0, d, f, pa, cm);
            chk("R7 neighbour kept", pa, {20'h00200 + 20'(i), 12'h000});
        end

        // R12: flush-all and fill on the same edge
        access(32'h0002_C000, 1'b0, 1'b0, 20'h0C0C0, 2'b00, 1'b0, 1'b1, 1'b0,
               wk, wa, ww, d, f, pa, cm);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0003_D000; req_priv = 1'b0; req_write = 1'b0;
        @(negedge clk);
        #2;
        set_fill(20'h0D0D0, 2'b11, 1'b0, 1'b1, 1'b0);
        fill_valid = 1'b1;
        flush_cmd = 2'b01;
        @(negedge clk);
        fill_valid = 1'b0;
        flush_cmd = 2'b00;
        #2;
        chk("R12 new entry survives", xl_paddr, 32'h0D0D_0000);
        #2;
        req_valid = 1'b0;
        probe(32'h0002_C000, 1'b0, 1'b0, d, f, pa, cm);
        chk("R12 old entry flushed", {31'b0, d}, 32'd0);

        // R8: fill order and round-robin eviction in set 9
        for (int i = 0; i < 5; i++) begin
            access({12'h000, 4'(i), 16'h9000}, 1'b0, 1'b0, 20'h00300 + 20'(i), 2'b00,
                   1'b0, 1'b1, 1'b0, wk, wa, ww, d, f, pa, cm);
        end
        for (int i = 1; i < 5; i++) begin
            probe({12'h000, 4'(i), 16'h9000}, 1'b0, 1'b0, d, f, pa, cm);
            chk("R8 resident", pa, {20'h00300 + 20'(i), 12'h000});
        end
        probe(32'h0000_9000, 1'b0, 1'b0, d, f, pa, cm);
        chk("R8 way0 evicted", {31'b0, d}, 32'd0);

        // R10: non-global flush keeps global entries
        access(32'h0006_A000, 1'b1, 1'b0, 20'h0A0A0, 2'b00, 1'b1, 1'b1, 1'b0,
               wk, wa, ww, d, f, pa, cm);
        access(32'h0007_A000, 1'b1, 1'b0, 20'h0B0B0, 2'b00, 1'b1, 1'b1, 1'b0,
               wk, wa, ww, d, f, pa, cm);
        flush(2'b10, 32'd0, 1'b0);
        probe(32'h0006_A000, 1'b1, 1'b0, d, f, pa, cm);
        chk("R10 global kept", pa, 32'h0A0A_0000);
        probe(32'h0001_9000, 1'b0, 1'b0, d, f, pa, cm);
        chk("R10 nonglobal gone", {31'b0, d}, 32'd0);

        // R11: single-entry flush
        flush(2'b11, 32'h0006_A000, 1'b0);
        probe(32'h0006_A000, 1'b1, 1'b0, d, f, pa, cm);
        chk("R11 priv mismatch kept", {31'b0, d}, 32'd1);
        flush(2'b11, 32'h0006_A000, 1'b1);
        probe(32'h0006_A000, 1'b1, 1'b0, d, f, pa, cm);
        chk("R11 global target gone", {31'b0, d}, 32'd0);
        probe(32'h0007_A000, 1'b1, 1'b0, d, f, pa, cm);
        chk("R11 other kept", pa, 32'h0B0B_0000);

        // R9: flush all
        flush(2'b01, 32'd0, 1'b0);
        probe(32'h0007_A000, 1'b1, 1'b0, d, f, pa, cm);
        chk("R9 all gone", {31'b0, d}, 32'd0);

        // R5: 8 KB pages
        @(negedge clk);
        page8k = 1'b1;
        access(32'h0001_3456, 1'b0, 1'b0, 20'h5555B, 2'b01, 1'b0, 1'b1, 1'b0,
               wk, wa, ww, d, f, pa, cm);
        chk("R5 paddr large page", pa, 32'h5555_B456);
        probe(32'h0001_2000, 1'b0, 1'b0, d, f, pa, cm);
        chk("R5 same page hit", pa, 32'h5555_A000);
        probe(32'h0000_3456, 1'b0, 1'b0, d, f, pa, cm);
        chk("R5 other index misses", {31'b0, d}, 32'd0);

        summary();
    end

endmodule